// File: doc/BRIEF.md
# User Mode Instruction Trap

This block sits between memory and the processor's data input and enforces a split between a privileged system mode and a restricted user mode. System software enters user mode by writing a control word. Once the machine is in user mode, software cannot get back out by itself. Only the processor's vector-pull cycle, which happens on any hardware or software interrupt, returns the machine to system mode. This gives the operating system a single, well-defined entry point.

While in user mode, the block watches every opcode fetch. Four instructions could disturb system stability: set-interrupt-disable ($78), stop-clock ($DB), wait-for-interrupt ($CB) and exchange-carry-with-emulation ($FB). When a fetch carries one of them, the block drives the no-operation opcode ($EA) to the processor instead. If non-maskable interrupt support is enabled, it also raises an NMI request so that the operating system can deal with the offender. On every other cycle, memory data passes straight through.

Top module: `priv_trap`

## Requirements
- R1: A control write (`ctl_we` high at a clock edge) made in system mode loads `ctl_wdata[0]` as the mode: 1 enters user mode and 0 keeps system mode. The same write loads `ctl_wdata[5]` as the NMI enable. `user_mode` shows the new value from the next cycle.
- R2: A control write made in user mode changes nothing. The mode stays user, and the NMI enable keeps the value it had before the write.
- R3: When `vec_pull_n` is low at a clock edge, `user_mode` is 0 from the next cycle. This takes priority over a control write at the same edge.
- R4: In user mode, a cycle with `op_fetch` high whose `mem_data` is $78, $DB, $CB or $FB drives `cpu_data` to $EA in that same cycle.
- R5: `cpu_data` equals `mem_data` in system mode, on every cycle with `op_fetch` low, and on user-mode fetches of any other opcode.
- R6: A substituted fetch made while the NMI enable is 1 drives `nmi_req` high for exactly `NMI_HOLD` cycles (default 2), starting on the cycle after the fetch. A further substituted fetch restarts that window.
- R7: A substituted fetch made while the NMI enable is 0 leaves `nmi_req` low, but the opcode is still replaced.
- R8: While `rst_n` is low, `user_mode` and `nmi_req` are 0, and the NMI enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_data | input | 8 | Data read from memory |
| op_fetch | input | 1 | High during an opcode fetch cycle |
| vec_pull_n | input | 1 | Vector pull from the processor, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data (bit 0 mode, bit 5 NMI enable) |
| cpu_data | output | 8 | Data driven to the processor |
| nmi_req | output | 1 | NMI request, active high |
| user_mode | output | 1 | Current mode, 1 = user |

## Verification
The opcode substitution and the pass-through are combinational, so they are due in the same cycle as the fetch. The mode bit and the NMI enable register at the edge, so `user_mode` reflects a write or a vector pull one cycle later. `nmi_req` rises one cycle after a trapping fetch and stays high for `NMI_HOLD` cycles. The driver applies each cycle's inputs just after the falling edge and queues that cycle's expected outputs. The monitor samples shortly before the next rising edge, so every comparison falls in the cycle where the result is due.

// File: rtl/priv_trap.sv
module priv_trap #(
  parameter int DW       = 8,
  parameter int NMI_HOLD = 2,
  parameter logic [DW-1:0] NOP_OP = 8'hEA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mem_data,
  input  logic          op_fetch,
  input  logic          vec_pull_n,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] cpu_data,
  output logic          nmi_req,
  output logic          user_mode
);
  localparam int CW = $clog2(NMI_HOLD + 1);
  localparam logic [CW-1:0] HOLD = CW'(NMI_HOLD);

  logic          mode_q, nmi_en_q;
  logic [CW-1:0] hold_q;
  logic          banned, trap;

  always_comb begin
    unique case (mem_data)
      8'h78, 8'hDB, 8'hCB, 8'hFB: banned = 1'b1;
      default:                    banned = 1'b0;
    endcase
  end

  assign trap      = mode_q && op_fetch && banned;
  assign cpu_data  = trap ? NOP_OP : mem_data;
  assign nmi_req   = hold_q != '0;
  assign user_mode = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      nmi_en_q <= 1'b0;
    end else if (!vec_pull_n) begin
      mode_q   <= 1'b0;
    end else if (ctl_we && !mode_q) begin
      mode_q   <= ctl_wdata[0];
      nmi_en_q <= ctl_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                hold_q <= '0;
    else if (trap && nmi_en_q) hold_q <= HOLD;
    else if (hold_q != '0)     hold_q <= hold_q - 1'b1;
  end
endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mem_data,
  input logic       op_fetch,
  input logic       vec_pull_n,
  input logic [7:0] cpu_data,
  input logic       nmi_req,
  input logic       user_mode
);
  logic bad_op;
  assign bad_op = mem_data == 8'h78 || mem_data == 8'hDB ||
                  mem_data == 8'hCB || mem_data == 8'hFB;

  assert_user_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode && vec_pull_n |=> user_mode);

  assert_vecpull_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_pull_n |=> !user_mode);

  assert_nop_subst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode && op_fetch && bad_op |-> cpu_data == 8'hEA);

  assert_pass_sys_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode || !op_fetch || !bad_op |-> cpu_data == mem_data);

  assert_nmi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |=> nmi_req);

  assert_nmi_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(user_mode && op_fetch && bad_op));
endmodule

bind priv_trap priv_trap_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .op_fetch(op_fetch),
  .vec_pull_n(vec_pull_n), .cpu_data(cpu_data), .nmi_req(nmi_req),
  .user_mode(user_mode)
);

// File: tb/test_priv_trap.sv
module test_priv_trap;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_data = 8'h00;
  logic       op_fetch = 1'b0;
  logic       vec_pull_n = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] cpu_data;
  logic       nmi_req, user_mode;

  always #2.5 clk = ~clk;

  priv_trap i_priv_trap (
    .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .op_fetch(op_fetch),
    .vec_pull_n(vec_pull_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cpu_data(cpu_data), .nmi_req(nmi_req), .user_mode(user_mode)
  );

  typedef struct {
    logic [7:0] data;
    logic       nmi;
    logic       mode;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0;
  logic m_mode = 0, m_en = 0;
  int   m_hold = 0;

  function automatic bit is_banned(logic [7:0] d);
    return d == 8'h78 || d == 8'hDB || d == 8'hCB || d == 8'hFB;
  endfunction

  task automatic step(input logic rst, input logic [7:0] md, input logic f,
                      input logic vp, input logic we, input logic [7:0] wd,
                      input string req);
    exp_t e;
    bit   trap;
    @(negedge clk);
    rst_n = rst; mem_data = md; op_fetch = f; vec_pull_n = vp;
    ctl_we = we; ctl_wdata = wd;
    trap   = m_mode && f && is_banned(md);
    e.data = trap ? 8'hEA : md;
    e.nmi  = m_hold != 0;
    e.mode = m_mode;
    e.req  = req;
    exp_q.push_back(e);
    if (!rst) begin
      m_mode = 0; m_en = 0; m_hold = 0;
    end else begin
      if (trap && m_en) m_hold = 2;
      else if (m_hold != 0) m_hold--;
      if (!vp) m_mode = 0;
      else if (we && !m_mode) begin m_mode = wd[0]; m_en = wd[5]; end
    end
  endtask

  task automatic idle(input string req);
    step(1, 8'h00, 0, 1, 0, 8'h00, req);
  endtask

  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total += 3;
      if (cpu_data !== e.data) begin
        bad++;
        $display("FAIL %s cpu_data actual=%h expected=%h", e.req, cpu_data, e.data);
      end
      if (nmi_req !== e.nmi) begin
        bad++;
        $display("FAIL %s nmi_req actual=%b expected=%b", e.req, nmi_req, e.nmi);
      end
      if (user_mode !== e.mode) begin
        bad++;
        $display("FAIL %s user_mode actual=%b expected=%b", e.req, user_mode, e.mode);
      end
    end
  end

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: reset state, and a write during reset is ignored
    step(0, 8'h78, 1, 1, 1, 8'h21, "R8");
    step(0, 8'h78, 1, 1, 0, 8'h00, "R8");
    idle("R8");
    // R5: system mode pass-through of banned opcodes
    step(1, 8'h78, 1, 1, 0, 8'h00, "R5");
    step(1, 8'hDB, 1, 1, 0, 8'h00, "R5");
    // R1: write 0 keeps system, then enter user with NMI enable
    step(1, 8'h00, 0, 1, 1, 8'h20, "R1");
    idle("R1");
    step(1, 8'h00, 0, 1, 1, 8'h21, "R1");
    idle("R1");
    // R4 R6: each banned opcode trapped
    step(1, 8'h78, 1, 1, 0, 8'h00, "R4");
    idle("R6"); idle("R6"); idle("R6");
    step(1, 8'hDB, 1, 1, 0, 8'h00, "R4");
    step(1, 8'hCB, 1, 1, 0, 8'h00, "R6");
    idle("R6"); idle("R6"); idle("R6");
    step(1, 8'hFB, 1, 1, 0, 8'h00, "R4");
    idle("R6");
    // R5: non-fetch and other opcodes pass in user mode
    step(1, 8'h78, 0, 1, 0, 8'h00, "R5");
    step(1, 8'hEA, 1, 1, 0, 8'h00, "R5");
    step(1, 8'h79, 1, 1, 0, 8'h00, "R5");
    idle("R5"); idle("R5");
    // R2: writes in user mode ignored, enable stays on
    step(1, 8'h00, 0, 1, 1, 8'h00, "R2");
    idle("R2");
    step(1, 8'hCB, 1, 1, 0, 8'h00, "R2");
    idle("R2"); idle("R2"); idle("R2");
    // R3: vector pull wins over a simultaneous write
    step(1, 8'h00, 0, 0, 1, 8'h21, "R3");
    idle("R3");
    step(1, 8'hFB, 1, 1, 0, 8'h00, "R3");
    // R7: user mode with NMI disabled
    step(1, 8'h00, 0, 1, 1, 8'h01, "R7");
    step(1, 8'hDB, 1, 1, 0, 8'h00, "R7");
    idle("R7"); idle("R7"); idle("R7");
    // R8: reset from user mode
    step(0, 8'h78, 1, 1, 0, 8'h00, "R8");
    step(1, 8'h78, 1, 1, 0, 8'h00, "R8");
    idle("R8");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule